// File: doc/BRIEF.md
# Index/Data Real-Time Clock

This block is a real-time clock on a byte-wide register bus. It uses an index/data pair. Software writes a register index to the index port. It then reads the selected register through the data port. The clock holds a binary, 24-hour calendar: seconds, minutes, hours, weekday, day of month, month and year. The calendar starts from a preset value set by parameters. It advances once per second, and it counts month lengths and leap years correctly.

A free-running divider makes a periodic interrupt pulse at 1024 Hz. With the default parameters, one second is 1024 of these pulses. The pulse does not depend on any register access. The three readable control registers return fixed images. One exception is the update-in-progress bit of control register A, which flips each time that register is read. The block does not support data-port writes, the fourth control register or unmapped indices. It flags each of these with a one-cycle error pulse.

Top module: `rtc_index_port`

## Requirements
- R1: `tick_irq_o` is a one-cycle pulse. It rises CLK_DIV cycles after reset and then every CLK_DIV cycles, whatever happens on the bus.
- R2: A write with `port_sel_i`=0 loads the 8-bit index. A read with `port_sel_i`=1 returns the selected register on `rdata_o` in the cycle after the request. Outside that cycle `rdata_o` is 0x00.
- R3: Index 10 (control A) reads {uip, 7'h26}. uip is 1 after reset and inverts after every read of index 10.
- R4: Index 11 (control B) always reads 0x46. Index 12 (control C) always reads 0x00.
- R5: Each of the following pulses `err_o` for one cycle with `rdata_o`=0x00, and changes no time or uip state: a data-port write, a read of index 13, a read of any index not in {0,2,4,6,7,8,9,10,11,12}, or a read of the index port.
- R6: Index 0 (seconds 0..59), index 2 (minutes 0..59) and index 4 (hours 0..23) read as binary values. The time advances by one second every TICKS_PER_SEC interrupt pulses. The first update lands on the cycle after pulse number TICKS_PER_SEC.
- R7: Index 6 (weekday) reads 0..6 with Sunday as 0. It increments modulo 7 when the time passes 23:59:59.
- R8: Index 7 (day of month) and index 8 (month, 1..12) follow month lengths of 31/30/28. February has 29 days in years divisible by four.
- R9: Index 9 reads (years since 1900) minus 52. It increments when 31 December passes midnight.
- R10: With default presets the clock starts at Sunday 1 January 2006, 00:00:00, so the year reads 54.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| port_sel_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| err_o | output | 1 | Unsupported access pulse |
| tick_irq_o | output | 1 | Periodic interrupt pulse |

## Verification
The bench runs three calendars side by side on one bus:
- The default preset.
- 31 December 2008 at 23:59:50, a Wednesday.
- 28 February 2008 at 23:59:55, a Thursday.

It reads every time register repeatedly across these rollovers. A design with a wrong month-length or leap rule would show 1 March instead of 29 February. A wrong weekday wrap would show 7. A year carry that fails would leave the year at 56.

Control register A is read several times in a row to catch a uip bit that sticks or toggles on other reads. Error accesses are mixed between ordinary reads, so a bad access that disturbs the index or uip shows up as a wrong value in a later read. The interrupt is compared on every cycle, which exposes an off-by-one divider.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] IDX_SEC   = 8'd0;
  localparam logic [7:0] IDX_MIN   = 8'd2;
  localparam logic [7:0] IDX_HOUR  = 8'd4;
  localparam logic [7:0] IDX_WDAY  = 8'd6;
  localparam logic [7:0] IDX_MDAY  = 8'd7;
  localparam logic [7:0] IDX_MON   = 8'd8;
  localparam logic [7:0] IDX_YEAR  = 8'd9;
  localparam logic [7:0] IDX_CTL_A = 8'd10;
  localparam logic [7:0] IDX_CTL_B = 8'd11;
  localparam logic [7:0] IDX_CTL_C = 8'd12;

  localparam logic [6:0] CTL_A_BASE = 7'h26;
  localparam logic [7:0] CTL_B_IMG  = 8'h46;
  localparam logic [7:0] CTL_C_IMG  = 8'h00;
  localparam logic [7:0] YEAR_BIAS  = 8'd52;

  typedef struct packed {
    logic [7:0] year;  // years since 1900
    logic [3:0] mon;   // 1..12
    logic [4:0] mday;  // 1..31
    logic [2:0] wday;  // 0..6, Sunday = 0
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  function automatic logic [4:0] month_len(logic [3:0] mon, logic [7:0] year);
    logic leap;
    leap = (year[1:0] == 2'b00) && (year != 8'd0);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
      4'd2:                    month_len = leap ? 5'd29 : 5'd28;
      default:                 month_len = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int CLK_DIV       = 32768,
  parameter int TICKS_PER_SEC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic sec_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int SW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sub_q;
  logic          wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sub_q  <= '0;
      tick_o <= 1'b0;
      sec_o  <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      tick_o <= wrap;
      sec_o  <= wrap && (sub_q == SUB_LAST);
      if (wrap) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end
  end

  // R1
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CLK_DIV > 1 && tick_o) |=> !tick_o);
  // R6
  sec_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |-> tick_o);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter rtc_time_t PRESET = '0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sec_i,
  output rtc_time_t time_o
);
  rtc_time_t t_q;
  logic [4:0] mlen;

  assign mlen   = month_len(t_q.mon, t_q.year);
  assign time_o = t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= PRESET;
    end else if (sec_i) begin
      if (t_q.sec != 6'd59) t_q.sec <= t_q.sec + 1'b1;
      else begin
        t_q.sec <= '0;
        if (t_q.min != 6'd59) t_q.min <= t_q.min + 1'b1;
        else begin
          t_q.min <= '0;
          if (t_q.hour != 5'd23) t_q.hour <= t_q.hour + 1'b1;
          else begin
            t_q.hour <= '0;
            t_q.wday <= (t_q.wday == 3'd6) ? 3'd0 : t_q.wday + 1'b1;
            if (t_q.mday != mlen) t_q.mday <= t_q.mday + 1'b1;
            else begin
              t_q.mday <= 5'd1;
              if (t_q.mon != 4'd12) t_q.mon <= t_q.mon + 1'b1;
              else begin
                t_q.mon  <= 4'd1;
                t_q.year <= t_q.year + 1'b1;
              end
            end
          end
        end
      end
    end
  end

  // R6
  hms_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_q.sec < 6'd60 && t_q.min < 6'd60 && t_q.hour < 5'd24);
  // R6
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_i |=> $stable(t_q));
  // R7
  wday_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_q.wday < 3'd7);
  // R8
  date_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_q.mday >= 5'd1 && t_q.mday <= mlen && t_q.mon >= 4'd1 && t_q.mon <= 4'd12);
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic       port_sel_i,
  input  logic [7:0] wdata_i,
  input  rtc_time_t  time_i,
  output logic [7:0] rdata_o,
  output logic       err_o
);
  logic [7:0] idx_q;
  logic       uip_q;
  logic       rd_data, wr_data, rd_idx, wr_idx;
  logic [7:0] val;
  logic       bad;

  assign rd_data = cs_i & ~wr_i &  port_sel_i;
  assign wr_data = cs_i &  wr_i &  port_sel_i;
  assign rd_idx  = cs_i & ~wr_i & ~port_sel_i;
  assign wr_idx  = cs_i &  wr_i & ~port_sel_i;

  always_comb begin
    val = 8'h00;
    bad = 1'b0;
    case (idx_q)
      IDX_SEC:   val = {2'b00, time_i.sec};
      IDX_MIN:   val = {2'b00, time_i.min};
      IDX_HOUR:  val = {3'b000, time_i.hour};
      IDX_WDAY:  val = {5'b00000, time_i.wday};
      IDX_MDAY:  val = {3'b000, time_i.mday};
      IDX_MON:   val = {4'b0000, time_i.mon};
      IDX_YEAR:  val = time_i.year - YEAR_BIAS;
      IDX_CTL_A: val = {uip_q, CTL_A_BASE};
      IDX_CTL_B: val = CTL_B_IMG;
      IDX_CTL_C: val = CTL_C_IMG;
      default:   bad = 1'b1;  // control D and unmapped
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      uip_q   <= 1'b1;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= (rd_data && !bad) ? val : 8'h00;
      err_o   <= (rd_data && bad) || wr_data || rd_idx;
      if (wr_idx) idx_q <= wdata_i;
      if (rd_data && idx_q == IDX_CTL_A) uip_q <= ~uip_q;
    end
  end

  // R3
  uip_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && idx_q == IDX_CTL_A) |=> (uip_q != $past(uip_q)));
  // R3
  uip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_data && idx_q == IDX_CTL_A) |=> $stable(uip_q));
  // R5
  wr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (err_o && rdata_o == 8'h00));
  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (rdata_o == 8'h00 && !err_o));
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_pkg::*;
#(
  parameter int         CLK_DIV       = 32768,
  parameter int         TICKS_PER_SEC = 1024,
  parameter logic [7:0] PRESET_YEAR   = 8'd106,
  parameter logic [3:0] PRESET_MON    = 4'd1,
  parameter logic [4:0] PRESET_MDAY   = 5'd1,
  parameter logic [2:0] PRESET_WDAY   = 3'd0,
  parameter logic [4:0] PRESET_HOUR   = 5'd0,
  parameter logic [5:0] PRESET_MIN    = 6'd0,
  parameter logic [5:0] PRESET_SEC    = 6'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic       port_sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       err_o,
  output logic       tick_irq_o
);
  localparam rtc_time_t PRESET = '{year: PRESET_YEAR, mon: PRESET_MON, mday: PRESET_MDAY,
                                   wday: PRESET_WDAY, hour: PRESET_HOUR, min: PRESET_MIN,
                                   sec: PRESET_SEC};

  logic      sec_pulse;
  rtc_time_t cur_time;

  rtc_tick_gen #(.CLK_DIV(CLK_DIV), .TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick_irq_o), .sec_o(sec_pulse)
  );

  rtc_calendar #(.PRESET(PRESET)) u_cal (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_i(sec_pulse), .time_o(cur_time)
  );

  rtc_regfile u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i), .port_sel_i(port_sel_i),
    .wdata_i(wdata_i), .time_i(cur_time), .rdata_o(rdata_o), .err_o(err_o)
  );
endmodule

// File: tb/sim_rtc_index_port.sv
module sim_rtc_index_port;
  localparam int PERIOD = 10;
  localparam int DIV    = 3;
  localparam int TPS    = 4;
  localparam int SPAN   = DIV * TPS;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_i = 0, wr_i = 0, port_sel_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rd [3];
  logic       er [3];
  logic       ti [3];

  int checks = 0, errors = 0;
  int ecnt = 0;
  int uip_m = 1;
  bit done = 0, run = 0;

  // presets per instance: year, mon, mday, wday, hour, min, sec
  int p_y [3] = '{106, 108, 108};
  int p_mo[3] = '{1, 12, 2};
  int p_d [3] = '{1, 31, 28};
  int p_wd[3] = '{0, 3, 4};
  int p_h [3] = '{0, 23, 23};
  int p_mi[3] = '{0, 59, 59};
  int p_s [3] = '{0, 50, 55};

  always #(PERIOD/2) clk_i = ~clk_i;

  rtc_index_port #(.CLK_DIV(DIV), .TICKS_PER_SEC(TPS)) u0 (
    .clk_i, .rst_ni, .cs_i, .wr_i, .port_sel_i, .wdata_i,
    .rdata_o(rd[0]), .err_o(er[0]), .tick_irq_o(ti[0]));
  rtc_index_port #(.CLK_DIV(DIV), .TICKS_PER_SEC(TPS), .PRESET_YEAR(8'd108),
    .PRESET_MON(4'd12), .PRESET_MDAY(5'd31), .PRESET_WDAY(3'd3), .PRESET_HOUR(5'd23),
    .PRESET_MIN(6'd59), .PRESET_SEC(6'd50)) u1 (
    .clk_i, .rst_ni, .cs_i, .wr_i, .port_sel_i, .wdata_i,
    .rdata_o(rd[1]), .err_o(er[1]), .tick_irq_o(ti[1]));
  rtc_index_port #(.CLK_DIV(DIV), .TICKS_PER_SEC(TPS), .PRESET_YEAR(8'd108),
    .PRESET_MON(4'd2), .PRESET_MDAY(5'd28), .PRESET_WDAY(3'd4), .PRESET_HOUR(5'd23),
    .PRESET_MIN(6'd59), .PRESET_SEC(6'd55)) u2 (
    .clk_i, .rst_ni, .cs_i, .wr_i, .port_sel_i, .wdata_i,
    .rdata_o(rd[2]), .err_o(er[2]), .tick_irq_o(ti[2]));

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ecnt <= 0; else ecnt <= ecnt + 1;

  function automatic int mlen(int mo, int y);
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return (y % 4 == 0 && y != 0) ? 29 : 28;
    return 31;
  endfunction

  function automatic int exp_reg(int k, int idx, int el);
    int y = p_y[k], mo = p_mo[k], d = p_d[k], wd = p_wd[k];
    int h = p_h[k], mi = p_mi[k], s = p_s[k];
    for (int n = 0; n < el; n++) begin
      s++;
      if (s == 60) begin s = 0; mi++; end
      if (mi == 60) begin mi = 0; h++; end
      if (h == 24) begin
        h = 0; wd = (wd + 1) % 7; d++;
        if (d > mlen(mo, y)) begin d = 1; mo++; end
        if (mo == 13) begin mo = 1; y++; end
      end
    end
    case (idx)
      0: return s;  2: return mi; 4: return h;  6: return wd;
      7: return d;  8: return mo; 9: return (y - 52) & 255;
      11: return 8'h46;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R1: interrupt compared every cycle
  always @(negedge clk_i) if (run) begin
    for (int k = 0; k < 3; k++)
      chk("R1", ti[k], (ecnt > 0 && ecnt % DIV == 0) ? 1 : 0);
  end

  task automatic bus(bit w, bit ps, logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; wr_i = w; port_sel_i = ps; wdata_i = d;
    @(negedge clk_i);
    cs_i = 0; wr_i = 0; port_sel_i = 0; wdata_i = 0;
  endtask

  task automatic set_idx(int idx);
    bus(1, 0, 8'(idx));
    for (int k = 0; k < 3; k++) chk("R2", {er[k], rd[k]}, 0);
  endtask

  // read data port; outputs observed at the negedge after the capture edge
  task automatic rd_reg(string req, int idx);
    int el, e;
    bit is_bad;
    bus(0, 1, 8'h00);
    e = ecnt;
    el = (e < 2) ? 0 : (e - 2) / SPAN;
    is_bad = !(idx inside {0, 2, 4, 6, 7, 8, 9, 10, 11, 12});
    for (int k = 0; k < 3; k++) begin
      if (idx == 10) chk(req, rd[k], (uip_m << 7) | 8'h26);
      else           chk(req, rd[k], exp_reg(k, idx, el));
      chk(req, er[k], is_bad ? 1 : 0);
    end
    if (idx == 10) uip_m = 1 - uip_m;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 3; k++) chk("R2 reset", {ti[k], er[k], rd[k]}, 0);
    rst_ni = 1;
    run = 1;
    // R10: default preset
    set_idx(0); rd_reg("R10", 0);
    set_idx(9); rd_reg("R10 R9", 9);
    set_idx(6); rd_reg("R10 R7", 6);
    set_idx(7); rd_reg("R10 R8", 7);
    // R3: uip toggles per read of A, starting at 1
    set_idx(10); rd_reg("R3", 10); rd_reg("R3", 10); rd_reg("R3", 10);
    // R4
    set_idx(11); rd_reg("R4", 11);
    set_idx(12); rd_reg("R4", 12);
    // R5: unsupported accesses
    set_idx(13);  rd_reg("R5", 13);
    set_idx(5);   rd_reg("R5", 5);
    set_idx(255); rd_reg("R5", 255);
    set_idx(10);
    bus(1, 1, 8'h55);
    for (int k = 0; k < 3; k++) begin chk("R5 wr", er[k], 1); chk("R5 wr", rd[k], 0); end
    bus(0, 0, 8'h00);
    for (int k = 0; k < 3; k++) begin chk("R5 idx", er[k], 1); chk("R5 idx", rd[k], 0); end
    rd_reg("R5 R3 uip kept", 10);
    // R6..R9 across rollovers
    for (int it = 0; it < 30; it++) begin
      set_idx(0); rd_reg("R6", 0);
      set_idx(2); rd_reg("R6", 2);
      set_idx(4); rd_reg("R6", 4);
      set_idx(6); rd_reg("R7", 6);
      set_idx(7); rd_reg("R8", 7);
      set_idx(8); rd_reg("R8", 8);
      set_idx(9); rd_reg("R9", 9);
    end
    set_idx(10); rd_reg("R3 late", 10);
    done = 1;
    run = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule